// File: doc/BRIEF.md
# Serial Memory Fast-Read Target

This block is the target side of a serial memory port. It watches chip select, serial clock and serial input, decodes a single fast-read command, and streams bytes on a serial output with its own output enable. The bytes come from two internal stores: a page buffer and a multi-page array. A preload port fills both stores. A configuration input, `cfg_buf`, picks one of two read styles. In column mode the host gives a 16-bit starting column, and output stops with the last buffer byte. In streaming mode the column bits are ignored, output starts at buffer byte 0, and it then runs through the array page by page. After the last array page it wraps to array page 0.

All pins are sampled with the system clock `clk`, so the serial clock must run at least eight times slower than `clk`. Each page holds `PAGE_DATA + PAGE_SPARE` bytes, and the buffer is the same size as one page. Streaming mode treats the buffer as the copy of array page 0. After the buffer it therefore continues with array page 1, then pages 2 and up to `PAGES-1`, then array page 0, and so on.

The controller is a state machine with these states: `ST_IDLE` (chip select high), `ST_CMD` (opcode bits), `ST_ADDR` (column bits, column mode only), `ST_DUMMY` (dummy clocks), `ST_DATA` (bytes driven), `ST_DRAINED` (buffer exhausted, output released) and `ST_REJECT` (wrong opcode). The transitions are as follows:
- Any state goes to IDLE when chip select is high.
- IDLE goes to CMD when chip select is low.
- CMD goes to ADDR (column mode) or DUMMY (streaming mode) at the eighth rising edge if the opcode matches. Otherwise it goes to REJECT.
- ADDR goes to DUMMY at rising edge 23.
- DUMMY goes to DATA at rising edge 47.
- DATA goes to DRAINED at a byte boundary where no valid byte remains.

Top module: `fast_read_target`

## Requirements
- R1: After reset, and whenever chip select is high, `spi_so_oe` is 0. A command is the 8-bit opcode 0x0C shifted in on `spi_si`, most significant bit first, sampled on serial clock rising edges 0 to 7 after chip select falls.
- R2: With `cfg_buf`=1 (column mode), rising edges 8 to 23 carry a 16-bit column, most significant bit first. Edges 24 to 47 are dummy clocks. `spi_so_oe` stays 0 through all 48 header edges. Bit 7 of the first byte is driven after the falling edge that follows rising edge 47.
- R3: With `cfg_buf`=0 (streaming mode), rising edges 8 to 47 are 40 dummy clocks and their data values have no effect. The first byte is buffer byte 0.
- R4: Each byte leaves most significant bit first. `spi_so` changes only after a serial clock falling edge, with one bit per falling edge.
- R5: The byte address advances by one after every byte, for as long as chip select stays low.
- R6: In column mode, output runs from the given column to the last buffer byte. At the falling edge where the next byte would start, `spi_so_oe` returns to 0 and stays there. A column at or beyond the buffer size gives no output.
- R7: In streaming mode, the byte after the last buffer byte is byte 0 of array page 1. Each array page is followed by the next, and the last array page is followed by array page 0.
- R8: Raising chip select ends a command at any bit. `spi_so_oe` falls within 4 `clk` cycles, and the next command starts from a cleared state.
- R9: The serial clock may idle low or high, that is SPI mode 0 or mode 3. A falling edge before the first rising edge is ignored.
- R10: Any opcode other than 0x0C leaves `spi_so_oe` at 0 until chip select goes high.
- R11: A `clk` cycle with `pre_we`=1 writes `pre_data` into the buffer (`pre_to_array`=0, at column `pre_col`) or into the array (`pre_to_array`=1, at page `pre_page`, column `pre_col`). Later reads return the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_buf | input | 1 | 1 selects column mode, 0 selects streaming mode; captured at the end of the opcode |
| pre_we | input | 1 | Preload write strobe |
| pre_to_array | input | 1 | Preload target: 0 is the buffer, 1 is the array |
| pre_page | input | clog2(PAGES) | Preload array page |
| pre_col | input | clog2(PAGE_DATA+PAGE_SPARE) | Preload byte column |
| pre_data | input | 8 | Preload byte |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for `spi_so` (0 means high impedance) |

## Verification
Each pin passes through two synchronizer stages and one edge-detect stage, so every serial result lands in the third `clk` cycle after the pin change. The bench holds each serial clock half period for 8 `clk` cycles and samples `spi_so` and `spi_so_oe` on the last cycle of the low half, just before it raises the clock again. The sample taken before rising edge 48+k is data bit k, and bit k of every header is also checked for a disabled output. After chip select rises, the bench waits 8 cycles before it checks that the output is released. This is more than the 4-cycle bound.

// File: rtl/fr_pkg.sv
`timescale 1ns/1ps
package fr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_DRAINED,
        ST_REJECT
    } fr_state_e;

    localparam logic [7:0] FR_OPCODE   = 8'h0C;
    localparam int         FR_CMD_BITS = 8;
    localparam int         FR_COL_BITS = 16;
    localparam int         FR_HDR_BITS = 48;

    localparam logic [5:0] FR_CMD_LAST = 6'(FR_CMD_BITS - 1);
    localparam logic [5:0] FR_COL_LAST = 6'(FR_CMD_BITS + FR_COL_BITS - 1);
    localparam logic [5:0] FR_HDR_LAST = 6'(FR_HDR_BITS - 1);

endpackage

// File: rtl/fr_pin_sync.sv
`timescale 1ns/1ps
module fr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic cs_n_s,
    output logic mosi_s,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] cs_sh;
    logic [STAGES-1:0] mosi_sh;
    logic [STAGES:0]   sclk_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sh   <= '1;
            mosi_sh <= '0;
            sclk_sh <= '0;
        end else begin
            cs_sh[0]   <= cs_n;
            mosi_sh[0] <= mosi;
            sclk_sh[0] <= sclk;
            sclk_sh[STAGES] <= sclk_sh[STAGES-1];
            for (int i = 1; i < STAGES; i++) begin
                cs_sh[i]   <= cs_sh[i-1];
                mosi_sh[i] <= mosi_sh[i-1];
                sclk_sh[i] <= sclk_sh[i-1];
            end
        end
    end

    assign cs_n_s = cs_sh[STAGES-1];
    assign mosi_s = mosi_sh[STAGES-1];
    assign rise   = sclk_sh[STAGES-1] & ~sclk_sh[STAGES];
    assign fall   = ~sclk_sh[STAGES-1] & sclk_sh[STAGES];

endmodule

// File: rtl/fr_store.sv
`timescale 1ns/1ps
module fr_store #(
    parameter int BUF_BYTES = 16,
    parameter int PAGES     = 4,
    localparam int CW = $clog2(BUF_BYTES),
    localparam int PW = $clog2(PAGES),
    localparam int AW = $clog2(PAGES * BUF_BYTES)
) (
    input  logic          clk,
    input  logic          pre_we,
    input  logic          pre_to_array,
    input  logic [PW-1:0] pre_page,
    input  logic [CW-1:0] pre_col,
    input  logic [7:0]    pre_data,
    input  logic          rd_from_buf,
    input  logic [PW-1:0] rd_page,
    input  logic [CW-1:0] rd_col,
    output logic [7:0]    rd_data
);

    logic [7:0] buf_mem [BUF_BYTES];
    logic [7:0] arr_mem [PAGES * BUF_BYTES];
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] rd_idx;

    assign wr_idx = AW'(pre_page) * AW'(BUF_BYTES) + AW'(pre_col);
    assign rd_idx = AW'(rd_page) * AW'(BUF_BYTES) + AW'(rd_col);

    always_ff @(posedge clk) begin
        if (pre_we) begin
            if (pre_to_array) arr_mem[wr_idx] <= pre_data;
            else              buf_mem[pre_col] <= pre_data;
        end
    end

    assign rd_data = rd_from_buf ? buf_mem[rd_col] : arr_mem[rd_idx];

endmodule

// File: rtl/fr_addr_seq.sv
`timescale 1ns/1ps
module fr_addr_seq #(
    parameter int BUF_BYTES = 16,
    parameter int PAGES     = 4,
    localparam int CW = $clog2(BUF_BYTES),
    localparam int PW = $clog2(PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          start,
    input  logic          col_mode,
    input  logic [15:0]   start_col,
    input  logic          advance,
    output logic          rd_valid,
    output logic          rd_from_buf,
    output logic [PW-1:0] rd_page,
    output logic [CW-1:0] rd_col
);

    localparam logic [16:0]   COL_LIM  = 17'(BUF_BYTES);
    localparam logic [CW-1:0] LAST_COL = CW'(BUF_BYTES - 1);
    localparam logic [PW-1:0] LAST_PG  = PW'(PAGES - 1);

    logic          valid_q;
    logic          from_buf_q;
    logic          mode_q;
    logic [PW-1:0] page_q;
    logic [CW-1:0] col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            from_buf_q <= 1'b1;
            mode_q     <= 1'b1;
            page_q     <= '0;
            col_q      <= '0;
        end else if (clear) begin
            valid_q    <= 1'b0;
            from_buf_q <= 1'b1;
            page_q     <= '0;
            col_q      <= '0;
        end else if (start) begin
            mode_q     <= col_mode;
            from_buf_q <= 1'b1;
            page_q     <= '0;
            if (col_mode) begin
                col_q   <= start_col[CW-1:0];
                valid_q <= ({1'b0, start_col} < COL_LIM);
            end else begin
                col_q   <= '0;
                valid_q <= 1'b1;
            end
        end else if (advance && valid_q) begin
            if (col_q != LAST_COL) begin
                col_q <= col_q + 1'b1;
            end else if (mode_q) begin
                valid_q <= 1'b0;
            end else begin
                col_q      <= '0;
                from_buf_q <= 1'b0;
                page_q     <= (page_q == LAST_PG) ? '0 : page_q + 1'b1;
            end
        end
    end

    assign rd_valid    = valid_q;
    assign rd_from_buf = from_buf_q;
    assign rd_page     = page_q;
    assign rd_col      = col_q;

    // R6: a valid byte in column mode is always inside the buffer
    p_col_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && mode_q) |-> (col_q <= LAST_COL && from_buf_q));

    // R7: last array page rolls to array page zero
    p_page_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && valid_q && !mode_q && !from_buf_q && !start && !clear
         && page_q == LAST_PG && col_q == LAST_COL)
        |=> (page_q == '0 && col_q == '0 && valid_q));

endmodule

// File: rtl/fr_ctrl.sv
`timescale 1ns/1ps
module fr_ctrl
    import fr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n_s,
    input  logic        mosi_s,
    input  logic        rise,
    input  logic        fall,
    input  logic        cfg_buf,
    input  logic [7:0]  rd_data,
    input  logic        rd_valid,
    output logic        seq_clear,
    output logic        seq_start,
    output logic        seq_col_mode,
    output logic [15:0] seq_col,
    output logic        seq_advance,
    output logic        so,
    output logic        so_oe
);

    fr_state_e   state_q, st_d;
    logic [5:0]  cnt_q;
    logic [15:0] sh_q;
    logic        mode_q;
    logic [7:0]  op_next;
    logic [2:0]  bit_q;
    logic [7:0]  byte_q;
    logic        so_q;
    logic        oe_q;

    assign op_next = {sh_q[6:0], mosi_s};

    always_comb begin
        st_d = state_q;
        if (cs_n_s) begin
            st_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  st_d = ST_CMD;
                ST_CMD: begin
                    if (rise && cnt_q == FR_CMD_LAST) begin
                        if (op_next == FR_OPCODE) st_d = cfg_buf ? ST_ADDR : ST_DUMMY;
                        else                      st_d = ST_REJECT;
                    end
                end
                ST_ADDR:  if (rise && cnt_q == FR_COL_LAST) st_d = ST_DUMMY;
                ST_DUMMY: if (rise && cnt_q == FR_HDR_LAST) st_d = ST_DATA;
                ST_DATA:  if (fall && bit_q == 3'd0 && !rd_valid) st_d = ST_DRAINED;
                ST_DRAINED, ST_REJECT: st_d = state_q;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            mode_q  <= 1'b1;
        end else begin
            state_q <= st_d;
            if (cs_n_s || state_q == ST_IDLE) begin
                cnt_q <= '0;
                sh_q  <= '0;
            end else if (rise) begin
                if (cnt_q < FR_HDR_LAST) cnt_q <= cnt_q + 1'b1;
                if (state_q == ST_CMD || state_q == ST_ADDR)
                    sh_q <= {sh_q[14:0], mosi_s};
                if (state_q == ST_CMD && cnt_q == FR_CMD_LAST)
                    mode_q <= cfg_buf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_q   <= 1'b0;
            oe_q   <= 1'b0;
            bit_q  <= '0;
            byte_q <= '0;
        end else if (cs_n_s) begin
            oe_q  <= 1'b0;
            bit_q <= '0;
        end else if (state_q == ST_DATA && fall) begin
            if (bit_q == 3'd0) begin
                if (rd_valid) begin
                    byte_q <= rd_data;
                    so_q   <= rd_data[7];
                    oe_q   <= 1'b1;
                    bit_q  <= 3'd1;
                end else begin
                    oe_q <= 1'b0;
                end
            end else begin
                so_q  <= byte_q[3'd7 - bit_q];
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign seq_clear    = cs_n_s;
    assign seq_start    = (state_q == ST_DUMMY) && rise && (cnt_q == FR_HDR_LAST) && !cs_n_s;
    assign seq_col_mode = mode_q;
    assign seq_col      = sh_q;
    assign seq_advance  = (state_q == ST_DATA) && fall && (bit_q == 3'd0) && !cs_n_s;
    assign so           = so_q;
    assign so_oe        = oe_q;

    // R2: no drive during the header phases
    p_quiet_header_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD || state_q == ST_ADDR || state_q == ST_DUMMY) |-> !oe_q);

    // R4: serial output moves only on a falling edge
    p_so_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(so_q));

    // R6: drive only while in the data phase
    p_oe_in_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (state_q == ST_DATA));

    // R8: chip select high releases the output and returns to idle
    p_cs_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (!oe_q && state_q == ST_IDLE));

    // R10: rejected opcode keeps the output released
    p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REJECT) |-> !oe_q);

endmodule

// File: rtl/fast_read_target.sv
`timescale 1ns/1ps
module fast_read_target #(
    parameter int PAGE_DATA   = 12,
    parameter int PAGE_SPARE  = 4,
    parameter int PAGES       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int BUF_BYTES = PAGE_DATA + PAGE_SPARE,
    localparam int CW = $clog2(BUF_BYTES),
    localparam int PW = $clog2(PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_buf,
    input  logic          pre_we,
    input  logic          pre_to_array,
    input  logic [PW-1:0] pre_page,
    input  logic [CW-1:0] pre_col,
    input  logic [7:0]    pre_data,
    input  logic          spi_cs_n,
    input  logic          spi_sclk,
    input  logic          spi_si,
    output logic          spi_so,
    output logic          spi_so_oe
);

    logic          cs_n_s, mosi_s, rise, fall;
    logic          seq_clear, seq_start, seq_col_mode, seq_advance;
    logic [15:0]   seq_col;
    logic          rd_valid, rd_from_buf;
    logic [PW-1:0] rd_page;
    logic [CW-1:0] rd_col;
    logic [7:0]    rd_data;

    fr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_si),
        .cs_n_s(cs_n_s), .mosi_s(mosi_s), .rise(rise), .fall(fall)
    );

    fr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(cs_n_s), .mosi_s(mosi_s), .rise(rise), .fall(fall),
        .cfg_buf(cfg_buf), .rd_data(rd_data), .rd_valid(rd_valid),
        .seq_clear(seq_clear), .seq_start(seq_start),
        .seq_col_mode(seq_col_mode), .seq_col(seq_col),
        .seq_advance(seq_advance), .so(spi_so), .so_oe(spi_so_oe)
    );

    fr_addr_seq #(.BUF_BYTES(BUF_BYTES), .PAGES(PAGES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .clear(seq_clear), .start(seq_start), .col_mode(seq_col_mode),
        .start_col(seq_col), .advance(seq_advance),
        .rd_valid(rd_valid), .rd_from_buf(rd_from_buf),
        .rd_page(rd_page), .rd_col(rd_col)
    );

    fr_store #(.BUF_BYTES(BUF_BYTES), .PAGES(PAGES)) u_store (
        .clk(clk),
        .pre_we(pre_we), .pre_to_array(pre_to_array),
        .pre_page(pre_page), .pre_col(pre_col), .pre_data(pre_data),
        .rd_from_buf(rd_from_buf), .rd_page(rd_page), .rd_col(rd_col),
        .rd_data(rd_data)
    );

endmodule

// File: tb/tb_fast_read_target.sv
`timescale 1ns/1ps
module tb_fast_read_target;

    localparam int BUFN = 16;
    localparam int NPG  = 4;
    localparam int H    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_buf = 1'b1;
    logic pre_we = 1'b0;
    logic pre_to_array = 1'b0;
    logic [1:0] pre_page = '0;
    logic [3:0] pre_col = '0;
    logic [7:0] pre_data = '0;
    logic spi_cs_n = 1'b1;
    logic spi_sclk = 1'b0;
    logic spi_si = 1'b0;
    logic spi_so;
    logic spi_so_oe;

    fast_read_target dut (
        .clk(clk), .rst_n(rst_n), .cfg_buf(cfg_buf),
        .pre_we(pre_we), .pre_to_array(pre_to_array), .pre_page(pre_page),
        .pre_col(pre_col), .pre_data(pre_data),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_si(spi_si),
        .spi_so(spi_so), .spi_so_oe(spi_so_oe)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] exp_buf [BUFN];
    logic [7:0] exp_arr [NPG*BUFN];
    logic [7:0] got_b   [128];
    bit         got_all [128];
    bit         got_any [128];
    bit         hdr_oe;
    bit         first_bit;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic preload(input bit to_arr, input int pg, input int col, input logic [7:0] d);
        pre_we = 1'b1; pre_to_array = to_arr;
        pre_page = 2'(pg); pre_col = 4'(col); pre_data = d;
        tick(1);
        pre_we = 1'b0;
    endtask

    task automatic bit_cycle(input logic v, output logic so_s, output logic oe_s);
        spi_si = v;
        tick(H);
        so_s = spi_so;
        oe_s = spi_so_oe;
        spi_sclk = 1'b1;
        tick(H);
        spi_sclk = 1'b0;
    endtask

    // one command: 8 opcode bits, 40 header bits, then nbits data clocks
    task automatic xfer(input bit m3, input logic [7:0] op, input logic [39:0] hdr, input int nbits);
        logic so_s, oe_s;
        hdr_oe = 1'b0;
        for (int i = 0; i < 128; i++) begin
            got_b[i] = '0; got_all[i] = 1'b1; got_any[i] = 1'b0;
        end
        spi_sclk = m3;
        tick(H);
        spi_cs_n = 1'b0;
        tick(H);
        if (m3) begin
            spi_sclk = 1'b0;
        end
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(op[i], so_s, oe_s);
            hdr_oe |= oe_s;
        end
        for (int i = 39; i >= 0; i--) begin
            bit_cycle(hdr[i], so_s, oe_s);
            hdr_oe |= oe_s;
        end
        for (int j = 0; j < nbits; j++) begin
            bit_cycle(1'(j & 1), so_s, oe_s);
            if (j == 0) first_bit = so_s;
            got_b[j/8]   = {got_b[j/8][6:0], so_s};
            got_all[j/8] = got_all[j/8] & oe_s;
            got_any[j/8] = got_any[j/8] | oe_s;
        end
        if (m3) spi_sclk = 1'b1;
        tick(H);
        spi_cs_n = 1'b1;
        tick(H);
    endtask

    function automatic logic [7:0] stream_exp(input int n);
        int m;
        if (n < BUFN) return exp_buf[n];
        m = n - BUFN;
        return exp_arr[((1 + m / BUFN) % NPG) * BUFN + (m % BUFN)];
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        // R1: reset state
        chk("R1 reset oe", int'(spi_so_oe), 0);
        rst_n = 1'b1;
        tick(4);
        chk("R1 idle oe", int'(spi_so_oe), 0);

        // R11: preload both stores through the port
        for (int c = 0; c < BUFN; c++) begin
            exp_buf[c] = 8'((c * 11 + 144) & 255);
            preload(1'b0, 0, c, exp_buf[c]);
        end
        for (int p = 0; p < NPG; p++)
            for (int c = 0; c < BUFN; c++) begin
                exp_arr[p*BUFN+c] = 8'((p * 37 + c * 5 + 3) & 255);
                preload(1'b1, p, c, exp_arr[p*BUFN+c]);
            end

        // R2 R5 R6: column sweep in column mode, one byte past the end
        cfg_buf = 1'b1;
        for (int c = 0; c < BUFN; c++) begin
            xfer(1'b0, 8'h0C, {16'(c), 24'hA5F00F}, (BUFN - c + 1) * 8);
            chk("R2 header quiet", int'(hdr_oe), 0);
            chk("R4 first bit msb", int'(first_bit), int'(exp_buf[c][7]));
            for (int i = 0; i < BUFN - c; i++) begin
                chk(i == 0 ? "R2 first byte" : "R5 next byte", int'(got_b[i]), int'(exp_buf[c+i]));
                chk("R5 oe during byte", int'(got_all[i]), 1);
            end
            chk("R6 released at end", int'(got_any[BUFN-c]), 0);
        end

        // R6: columns beyond the buffer give nothing
        xfer(1'b0, 8'h0C, {16'd16, 24'h0}, 16);
        chk("R6 col 16 no output", int'(got_any[0] | got_any[1]), 0);
        xfer(1'b0, 8'h0C, {16'h8002, 24'h0}, 8);
        chk("R6 col 0x8002 no output", int'(got_any[0]), 0);

        // R3 R7: streaming mode through all pages and past the wrap
        cfg_buf = 1'b0;
        xfer(1'b0, 8'h0C, 40'hFF_A5_5A_C3_3C, (BUFN + NPG * BUFN + 3) * 8);
        chk("R3 header quiet", int'(hdr_oe), 0);
        for (int n = 0; n < BUFN + NPG * BUFN + 3; n++) begin
            chk(n < BUFN ? "R3 buffer byte" : "R7 array byte", int'(got_b[n]), int'(stream_exp(n)));
            chk("R7 oe held", int'(got_all[n]), 1);
        end

        // R9: mode 3 clock idle level in both modes
        xfer(1'b1, 8'h0C, 40'h0, 20 * 8);
        for (int n = 0; n < 20; n++)
            chk("R9 mode3 stream byte", int'(got_b[n]), int'(stream_exp(n)));
        cfg_buf = 1'b1;
        xfer(1'b1, 8'h0C, {16'd5, 24'hFFFFFF}, 4 * 8);
        chk("R9 mode3 header quiet", int'(hdr_oe), 0);
        for (int i = 0; i < 4; i++)
            chk("R9 mode3 column byte", int'(got_b[i]), int'(exp_buf[5+i]));

        // R10: wrong opcodes stay silent
        xfer(1'b0, 8'h0D, {16'd0, 24'h0}, 3 * 8);
        chk("R10 opcode 0D silent", int'(got_any[0] | got_any[1] | got_any[2] | hdr_oe), 0);
        xfer(1'b1, 8'h8C, {16'd0, 24'h0}, 3 * 8);
        chk("R10 opcode 8C silent", int'(got_any[0] | got_any[1] | got_any[2] | hdr_oe), 0);

        // R8: early chip-select release, then a fresh command
        xfer(1'b0, 8'h0C, {16'd2, 24'h0}, 2 * 8 + 3);
        chk("R8 byte before cut", int'(got_b[1]), int'(exp_buf[3]));
        chk("R8 released after cs", int'(spi_so_oe), 0);
        xfer(1'b0, 8'h0C, {16'd2, 24'h0}, 8);
        chk("R8 fresh start", int'(got_b[0]), int'(exp_buf[2]));

        // R11: rewrite one buffer byte and one array byte, read them back
        preload(1'b0, 0, 3, 8'h5E);
        exp_buf[3] = 8'h5E;
        xfer(1'b0, 8'h0C, {16'd3, 24'h0}, 8);
        chk("R11 buffer rewrite", int'(got_b[0]), 32'h5E);
        preload(1'b1, 1, 0, 8'hC7);
        exp_arr[BUFN] = 8'hC7;
        cfg_buf = 1'b0;
        xfer(1'b0, 8'h0C, 40'h0, (BUFN + 1) * 8);
        chk("R11 array rewrite", int'(got_b[BUFN]), 32'hC7);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule